// File: doc/BRIEF.md
# I2C Acknowledge Polling Sequencer

After a write command has been sent to a serial memory, the memory runs an internal programming cycle. While that cycle runs, it does not acknowledge its own address. This block sits on the master side and finds out when that cycle has finished. It opens a transaction with a start, sends the control byte with the direction bit set to write, and reads the acknowledge flag. A missing acknowledge is taken to mean the target is still busy, not that the bus has failed. The block then closes the attempt with a stop and tries again. Polling can begin as soon as the write command's own stop has been issued.

The block drives an external byte-level bus engine. It gives that engine one command at a time (start, byte or stop), each held until the engine accepts it. The engine answers every command with one response pulse, and for a byte that response carries the acknowledge flag. On the user side there are:
- a request carrying the 7-bit target address;
- a configuration bit that picks whether a successful probe is closed with a stop or left open for the next operation;
- a busy level;
- a one-cycle done pulse;
- a one-cycle timeout pulse, raised when a parameter-limited number of attempts has gone without an answer.

Top module: `ack_poll_seq`

## Requirements
- R1: While reset is held and after it is released with no request, busy, done, timeout_err and cmd_valid are all 0.
- R2: An accepted request makes the first command a start (cmd_op 0), and the next command a byte (cmd_op 1) whose value is the address in bits 7:1 with bit 0 equal to 0.
- R3: A byte response with rsp_ack 0, before the attempt limit is reached, is followed by a stop (cmd_op 2), then a new start and the same control byte.
- R4: A byte response with rsp_ack 1, when keep_open was 0 at the request, is followed by one stop; done pulses the cycle after that stop's response.
- R5: A byte response with rsp_ack 1, when keep_open was 1 at the request, issues no stop; done pulses the cycle after that byte response.
- R6: After MAX_TRIES attempts that all lack an acknowledge, one stop is issued, timeout_err pulses the cycle after that stop's response, and done does not pulse.
- R7: done and timeout_err each last exactly one cycle and are never high together.
- R8: A request that arrives while busy is 1 is ignored: it starts no commands and does not change the address being polled.
- R9: Once raised, cmd_valid stays high with cmd_op and cmd_byte unchanged until a cycle with cmd_ready high. No new command is raised while a response is still awaited.
- R10: busy is 1 from the cycle after an accepted request until the cycle in which done or timeout_err pulses, and 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a polling sequence (taken only when idle) |
| req_addr | input | 7 | Target address to probe |
| keep_open | input | 1 | 1: leave the transaction open after an acknowledge; 0: close it with a stop |
| busy | output | 1 | A polling sequence is in progress |
| done | output | 1 | One-cycle pulse: the target acknowledged |
| timeout_err | output | 1 | One-cycle pulse: the attempt limit was used up |
| cmd_valid | output | 1 | A command is offered to the bus engine |
| cmd_ready | input | 1 | The bus engine takes the offered command |
| cmd_op | output | 2 | 0 start, 1 send byte, 2 stop |
| cmd_byte | output | 8 | Byte to send when cmd_op is 1, else 0 |
| rsp_valid | input | 1 | One-cycle pulse: the engine finished the last accepted command |
| rsp_ack | input | 1 | With rsp_valid after a byte: 1 the target acknowledged |

## Verification
The assertions check on every cycle that the block keeps an offered command stable until it is accepted, and that it stays quiet on the command port while idle. They also check that each sequence opens with a start, that a missing acknowledge is answered by a stop, that the hand-over mode never emits a stop, that done and timeout_err are exclusive single pulses, and that a timeout only occurs once the attempt count has reached its limit. The scoreboard scenarios are needed to show that the whole command order matches a given number of busy answers. Those scenarios also show:
- the control byte carries the requested address;
- the limit is counted exactly, both at one below and at the limit;
- the completion pulses land the cycle after the last response;
- a request made during a sequence leaves no trace.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [1:0] {
    WHY_RETRY = 2'd0,
    WHY_OK    = 2'd1,
    WHY_TMO   = 2'd2
  } stop_why_e;

  // Control byte of a probe: address above, write direction (0) in bit 0.
  function automatic logic [BYTE_W-1:0] probe_byte(input logic [ADDR_W-1:0] a);
    return {a, 1'b0};
  endfunction

  // True when the attempt now in flight is the last one allowed.
  function automatic logic last_attempt(input int used, input int cap);
    return (used + 1) >= cap;
  endfunction
endpackage

// File: rtl/ap_attempt_ctr.sv
module ap_attempt_ctr #(
  parameter int MAX_TRIES = 8,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] used,
  output logic          at_cap
);
  always_ff @(posedge clk) begin
    if (!rst_n)   used <= '0;
    else if (clr) used <= '0;
    else if (inc) used <= used + 1'b1;
  end

  assign at_cap = ap_pkg::last_attempt(int'(used), MAX_TRIES);
endmodule

// File: rtl/ap_cmd_reg.sv
module ap_cmd_reg
  import ap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  bus_op_e           load_op,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte
);
  // One command at a time, held until the engine takes it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_byte  <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_op    <= load_op;
      cmd_byte  <= load_byte;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ap_ctrl.sv
module ap_ctrl
  import ap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              keep_open,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic              at_cap,
  output logic              ld,
  output bus_op_e           ld_op,
  output logic [BYTE_W-1:0] ld_byte,
  output logic              ctr_clr,
  output logic              ctr_inc,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              ev_ack,
  output logic              ev_nack,
  output logic              keep_q
);
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_START = 2'd1,
    ST_WAIT_BYTE  = 2'd2,
    ST_WAIT_STOP  = 2'd3
  } st_e;

  st_e               st, st_n;
  stop_why_e         why, why_n;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, done_n, tmo_n;

  assign busy    = (st != ST_IDLE);
  assign ev_ack  = (st == ST_WAIT_BYTE) && rsp_valid && rsp_ack;
  assign ev_nack = (st == ST_WAIT_BYTE) && rsp_valid && !rsp_ack;

  always_comb begin
    st_n    = st;
    why_n   = why;
    ld      = 1'b0;
    ld_op   = OP_START;
    ld_byte = '0;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    accept  = 1'b0;
    done_n  = 1'b0;
    tmo_n   = 1'b0;
    case (st)
      ST_IDLE: if (req_valid) begin
        accept  = 1'b1;
        ctr_clr = 1'b1;
        ld      = 1'b1;
        st_n    = ST_WAIT_START;
      end
      ST_WAIT_START: if (rsp_valid) begin
        ld      = 1'b1;
        ld_op   = OP_BYTE;
        ld_byte = probe_byte(addr_q);
        st_n    = ST_WAIT_BYTE;
      end
      ST_WAIT_BYTE: if (rsp_valid) begin
        if (rsp_ack && keep_q) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          ld    = 1'b1;
          ld_op = OP_STOP;
          st_n  = ST_WAIT_STOP;
          if (rsp_ack) begin
            why_n = WHY_OK;
          end else begin
            ctr_inc = 1'b1;
            why_n   = at_cap ? WHY_TMO : WHY_RETRY;
          end
        end
      end
      ST_WAIT_STOP: if (rsp_valid) begin
        case (why)
          WHY_RETRY: begin
            ld   = 1'b1;
            st_n = ST_WAIT_START;
          end
          WHY_OK: begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end
          default: begin
            tmo_n = 1'b1;
            st_n  = ST_IDLE;
          end
        endcase
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      why         <= WHY_RETRY;
      addr_q      <= '0;
      keep_q      <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st          <= st_n;
      why         <= why_n;
      done        <= done_n;
      timeout_err <= tmo_n;
      if (accept) begin
        addr_q <= req_addr;
        keep_q <= keep_open;
      end
    end
  end
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ap_pkg::*;
#(
  parameter int MAX_TRIES = 8,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              keep_open,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  input  logic              rsp_ack
);
  // Internal events, named for the bound checker.
  logic              ld, ctr_clr, ctr_inc, at_cap, ev_ack, ev_nack, keep_q;
  bus_op_e           ld_op;
  logic [BYTE_W-1:0] ld_byte;
  logic [CW-1:0]     tries_used;

  ap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .keep_open(keep_open),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .at_cap(at_cap),
    .ld(ld), .ld_op(ld_op), .ld_byte(ld_byte),
    .ctr_clr(ctr_clr), .ctr_inc(ctr_inc),
    .busy(busy), .done(done), .timeout_err(timeout_err),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .keep_q(keep_q)
  );

  ap_attempt_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc),
    .used(tries_used), .at_cap(at_cap)
  );

  ap_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n),
    .load(ld), .load_op(ld_op), .load_byte(ld_byte),
    .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte)
  );
endmodule

// File: rtl/ap_checker.sv
module ap_checker #(
  parameter int MAX_TRIES = 8,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          timeout_err,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_byte,
  input logic          ev_ack,
  input logic          ev_nack,
  input logic          keep_q,
  input logic [CW-1:0] tries_used
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);  // R1
  AST_OPEN_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && cmd_op == 2'd0);  // R2
  AST_NACK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> cmd_valid && cmd_op == 2'd2);  // R3
  AST_HANDOVER_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && keep_q |=> done && !cmd_valid);  // R5
  AST_TMO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> int'(tries_used) == MAX_TRIES);  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);  // R7
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));  // R7
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));  // R9
  AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done || timeout_err |-> !busy);  // R10
endmodule

bind ack_poll_seq ap_checker #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout_err(timeout_err),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
  .ev_ack(ev_ack), .ev_nack(ev_nack), .keep_q(keep_q), .tries_used(tries_used)
);

// File: tb/tb_ack_poll_seq.sv
module tb_ack_poll_seq;
  localparam int T = 5;
  localparam logic [1:0] C_START = 2'd0, C_BYTE = 2'd1, C_STOP = 2'd2;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, req_valid, keep_open, busy, done, timeout_err;
  logic cmd_valid, cmd_ready, rsp_valid, rsp_ack;
  logic [6:0] req_addr;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  ack_poll_seq #(.MAX_TRIES(T)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .keep_open(keep_open), .busy(busy), .done(done), .timeout_err(timeout_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  int total = 0, bad = 0, cyc = 0;
  int nack_left = 0, last_rsp_cyc = -10, n_done = 0, n_tmo = 0;
  string end_tag = "R4";
  logic [1:0] eng_op;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [1:0] op; logic [7:0] b; string tag; } item_t;
  item_t expq[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Bus engine model: stalls acceptance, answers each command once.
  initial begin
    cmd_ready = 0; rsp_valid = 0; rsp_ack = 0;
    forever begin
      @(posedge clk); #1;
      rsp_valid = 0;
      if (cmd_valid) begin
        eng_op = cmd_op;
        repeat (cyc % 3) @(posedge clk);
        #1 cmd_ready = 1;
        @(posedge clk); #1 cmd_ready = 0;
        repeat (1 + cyc % 2) @(posedge clk);
        #1 rsp_valid = 1;
        rsp_ack = 0;
        if (eng_op == C_BYTE) begin
          if (nack_left == 0) rsp_ack = 1;
          else nack_left--;
        end
        last_rsp_cyc = cyc;
      end
    end
  end

  // Scoreboard monitor for commands.
  logic pv_valid = 0, pv_ready = 0;
  logic [1:0] pv_op;
  logic [7:0] pv_byte;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_valid && !pv_ready) begin
        chk(cmd_valid == 1, "R9", "command dropped before accept", int'(cmd_valid), 1);
        chk(cmd_op == pv_op && cmd_byte == pv_byte, "R9", "command changed while held",
            int'({cmd_op, cmd_byte}), int'({pv_op, pv_byte}));
      end
      if (cmd_valid && cmd_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R8", "unexpected command op", int'(cmd_op), -1);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(cmd_op == e.op, e.tag, "command op", int'(cmd_op), int'(e.op));
          chk(cmd_byte == e.b, e.tag, "command byte", int'(cmd_byte), int'(e.b));
        end
      end
    end
    pv_valid = cmd_valid; pv_ready = cmd_ready; pv_op = cmd_op; pv_byte = cmd_byte;
  end

  // Completion monitor.
  logic pv_done = 0, pv_tmo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        n_done++;
        chk(cyc == last_rsp_cyc + 1, end_tag, "done latency cycle", cyc, last_rsp_cyc + 1);
      end
      if (timeout_err) begin
        n_tmo++;
        chk(cyc == last_rsp_cyc + 1, "R6", "timeout latency cycle", cyc, last_rsp_cyc + 1);
      end
      if (done || timeout_err) begin
        chk(!(done && timeout_err), "R7", "done and timeout together", 1, 0);
        chk(!busy, "R10", "busy at completion", int'(busy), 0);
      end
      if (pv_done) chk(!done, "R7", "done wider than one cycle", int'(done), 0);
      if (pv_tmo) chk(!timeout_err, "R7", "timeout wider than one cycle", int'(timeout_err), 0);
    end
    pv_done = done; pv_tmo = timeout_err;
  end

  task automatic run_poll(input logic [6:0] addr, input int nbusy, input bit keep, input bit meddle);
    int tries, guard;
    bit ok;
    ok = (nbusy < T);
    tries = ok ? nbusy + 1 : T;
    for (int a = 0; a < tries; a++) begin
      expq.push_back('{C_START, 8'h00, (a == 0) ? "R2" : "R3"});
      expq.push_back('{C_BYTE, {addr, 1'b0}, (a == 0) ? "R2" : "R3"});
      if (a < tries - 1) expq.push_back('{C_STOP, 8'h00, "R3"});
    end
    if (!ok) expq.push_back('{C_STOP, 8'h00, "R6"});
    else if (!keep) expq.push_back('{C_STOP, 8'h00, "R4"});
    end_tag = keep ? "R5" : "R4";
    n_done = 0; n_tmo = 0; nack_left = nbusy;
    @(posedge clk); #1;
    req_valid = 1; req_addr = addr; keep_open = keep;
    @(posedge clk); #1;
    req_valid = 0; keep_open = ~keep;
    @(negedge clk);
    chk(busy == 1, "R10", "busy after request", int'(busy), 1);
    if (meddle) begin
      repeat (2) @(posedge clk);
      #1 req_valid = 1; req_addr = ~addr;
      @(posedge clk); #1 req_valid = 0;
    end
    guard = 0;
    while (n_done + n_tmo == 0 && guard < 3000) begin
      @(negedge clk); guard++;
    end
    repeat (12) @(negedge clk);
    chk(n_done == (ok ? 1 : 0), ok ? end_tag : "R6", "done pulses", n_done, ok ? 1 : 0);
    chk(n_tmo == (ok ? 0 : 1), "R6", "timeout pulses", n_tmo, ok ? 0 : 1);
    chk(expq.size() == 0, meddle ? "R8" : "R3", "expected commands left over", expq.size(), 0);
    chk(busy == 0 && cmd_valid == 0, "R10", "idle after sequence", int'({busy, cmd_valid}), 0);
    expq.delete();
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; keep_open = 0;
    repeat (4) @(negedge clk);
    chk({busy, done, timeout_err, cmd_valid} == 4'b0, "R1", "outputs in reset",
        int'({busy, done, timeout_err, cmd_valid}), 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk({busy, done, timeout_err, cmd_valid} == 4'b0, "R1", "outputs idle after reset",
        int'({busy, done, timeout_err, cmd_valid}), 0);
    run_poll(7'h50, 0, 0, 0);      // R2 R4: immediate answer
    run_poll(7'h51, 3, 0, 0);      // R3: three busy probes
    run_poll(7'h2A, 2, 1, 0);      // R5: hand over without stop
    run_poll(7'h13, T - 1, 0, 0);  // R6 boundary: answer on last allowed attempt
    run_poll(7'h7F, T, 0, 0);      // R6: exactly at the limit
    run_poll(7'h01, T + 6, 1, 0);  // R6: well beyond, hand-over mode irrelevant
    run_poll(7'h33, 1, 0, 1);      // R8: request during sequence
    run_poll(7'h44, 0, 1, 1);      // R8 with R5
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule